// File: doc/BRIEF.md
# Negotiated Lockable Management Memory Window

This block guards a 128 KB management memory window that starts at byte address 0x30000. It sits between a byte-wide memory request port and a small RAM model. It holds one byte of configuration at offset 0x9C, and that byte decides whether memory traffic inside the window reaches RAM or is swallowed. At reset the window is ordinary memory. Software turns the guard on in two steps. It first writes a negotiation code and then a lock code. Every other value written along the way is ignored.

Once locked, the configuration byte cannot change, and the window is a black hole: reads inside it return 0xFF and writes inside it are dropped. Only a reset clears the lock. RAM is not cleared by reset, so data written before the lock is visible again afterwards. A parameter selects a legacy build in which the byte is a plain read/write register and memory is never gated.

Top module: `smw_window_gate`

## Requirements
- R1: After reset, the configuration byte at offset 0x9C reads 0x00 and `mem_rdata_o` is 0x00. Accesses at 0x30000 reach RAM: a write followed by a read returns the written byte.
- R2: While the byte reads 0x00, writing any value 0x00 through 0xFE to offset 0x9C leaves it at 0x00.
- R3: While the byte reads 0x00, writing 0xFF makes it read 0x01 (negotiated).
- R4: While the byte reads 0x01, writing 0x02 makes it read 0x02 (locked). Any other value leaves it at 0x01.
- R5: While the byte reads 0x02, no write value changes it.
- R6: While locked, a read at any address from 0x30000 through 0x4FFFF returns 0xFF, and a write there leaves RAM unchanged. Addresses outside that range behave as RAM.
- R7: Reset returns the byte to 0x00 and the window to plain RAM. RAM contents written before the lock survive the reset.
- R8: With LEGACY=1, any value written to offset 0x9C reads back exactly, and the window is never gated.
- R9: `cfg_rdata_o` is 0x00 whenever `cfg_addr_i` is not 0x9C, and writes to other offsets change nothing.
- R10: A read (`mem_req_i`=1, `mem_we_i`=0) places its data on `mem_rdata_o` at the next clock edge, and the value holds until the next read. The RAM model stores by the low RAM_AW address bits (256 bytes by default), so addresses alias modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| mem_req_i | input | 1 | Memory access request |
| mem_we_i | input | 1 | Memory write (1) or read (0) |
| mem_addr_i | input | ADDR_W | Memory byte address |
| mem_wdata_i | input | 8 | Memory write data |
| mem_rdata_o | output | 8 | Registered memory read data |

## Verification
The hardest state to reach is the lock together with its effect on RAM that was written before the lock. The stimulus fills RAM outside the window and writes a marker at the window base. It then sweeps all 255 ignored values, negotiates, and offers wrong codes before locking. Next it probes both edges of the window and the addresses just outside them, and writes into the black hole. Finally it resets and reads the marker back, which shows that the dropped write never reached RAM. A legacy instance shares the same stimulus, so each sweep also checks plain read-back and ungated memory.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;
  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_NEG  = 2'd1,
    ST_LOCK = 2'd2
  } smw_state_e;

  localparam logic [7:0] NEG_CODE  = 8'hFF;
  localparam logic [7:0] LOCK_CODE = 8'h02;
  localparam logic [7:0] RD_OPEN   = 8'h00;
  localparam logic [7:0] RD_NEG    = 8'h01;
  localparam logic [7:0] RD_LOCK   = 8'h02;
  localparam logic [7:0] HOLE_BYTE = 8'hFF;
endpackage

// File: rtl/smw_cfg_reg.sv
`timescale 1ns/1ps
module smw_cfg_reg
  import smw_pkg::*;
#(
  parameter logic [7:0] CFG_OFFSET = 8'h9C,
  parameter bit         LEGACY     = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] reg_val_o,
  output logic       lock_o
);
  logic hit_wr;
  assign hit_wr = cfg_wr_i && (cfg_addr_i == CFG_OFFSET);

  generate
    if (LEGACY) begin : g_plain
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     byte_q <= '0;
        else if (hit_wr) byte_q <= cfg_wdata_i;
      end
      assign reg_val_o = byte_q;
      assign lock_o    = 1'b0;

      assert_plain_rw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_wr |=> reg_val_o == $past(cfg_wdata_i));
    end else begin : g_fsm
      smw_state_e st_q, st_d;
      always_comb begin
        st_d = st_q;
        if (hit_wr) begin
          unique case (st_q)
            ST_OPEN: if (cfg_wdata_i == NEG_CODE)  st_d = ST_NEG;
            ST_NEG:  if (cfg_wdata_i == LOCK_CODE) st_d = ST_LOCK;
            default: st_d = st_q;
          endcase
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_OPEN;
        else         st_q <= st_d;
      end
      always_comb begin
        unique case (st_q)
          ST_NEG:  reg_val_o = RD_NEG;
          ST_LOCK: reg_val_o = RD_LOCK;
          default: reg_val_o = RD_OPEN;
        endcase
      end
      assign lock_o = (st_q == ST_LOCK);

      assert_ignore_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_val_o == RD_OPEN && hit_wr && cfg_wdata_i != NEG_CODE) |=> reg_val_o == RD_OPEN);
      assert_neg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_val_o == RD_NEG && hit_wr && cfg_wdata_i != LOCK_CODE) |=> reg_val_o == RD_NEG);
      assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_o |=> lock_o && $stable(reg_val_o));
    end
  endgenerate

  assert_other_offset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_wr) |=> $stable(reg_val_o));
endmodule

// File: rtl/smw_win_decode.sv
`timescale 1ns/1ps
module smw_win_decode #(
  parameter int          ADDR_W   = 20,
  parameter int unsigned WIN_BASE = 32'h3_0000,
  parameter int unsigned WIN_SIZE = 32'h2_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] LO = AW1'(WIN_BASE);
  localparam logic [AW1-1:0] HI = AW1'(WIN_BASE) + AW1'(WIN_SIZE);

  logic [AW1-1:0] a_ext;
  assign a_ext = {1'b0, addr_i};
  assign hit_o = (a_ext >= LO) && (a_ext < HI);
endmodule

// File: rtl/smw_ram.sv
`timescale 1ns/1ps
module smw_ram #(
  parameter int RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << RAM_AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/smw_window_gate.sv
`timescale 1ns/1ps
module smw_window_gate
  import smw_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          RAM_AW     = 8,
  parameter int unsigned WIN_BASE   = 32'h3_0000,
  parameter int unsigned WIN_SIZE   = 32'h2_0000,
  parameter logic [7:0]  CFG_OFFSET = 8'h9C,
  parameter bit          LEGACY     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o
);
  logic [7:0] reg_val;
  logic       locked, win_hit, blocked, ram_we;
  logic [7:0] ram_q, rd_q;

  smw_cfg_reg #(.CFG_OFFSET(CFG_OFFSET), .LEGACY(LEGACY)) u_cfg (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i,
    .reg_val_o(reg_val), .lock_o(locked)
  );

  smw_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
    .addr_i(mem_addr_i), .hit_o(win_hit)
  );

  assign blocked = locked && win_hit;
  assign ram_we  = mem_req_i && mem_we_i && !blocked;

  smw_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk_i, .we_i(ram_we), .addr_i(mem_addr_i[RAM_AW-1:0]),
    .wdata_i(mem_wdata_i), .rdata_o(ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rd_q <= '0;
    else if (mem_req_i && !mem_we_i) rd_q <= blocked ? HOLE_BYTE : ram_q;
  end

  assign mem_rdata_o = rd_q;
  assign cfg_rdata_o = (cfg_addr_i == CFG_OFFSET) ? reg_val : 8'h00;

  assert_hole_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && locked && win_hit) |=> mem_rdata_o == HOLE_BYTE);
  assert_ram_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && !win_hit) |=> mem_rdata_o == $past(ram_q));
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_i && !mem_we_i) |=> $stable(mem_rdata_o));
  assert_no_lock_legacy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEGACY |-> !locked);
endmodule

// File: tb/tb_smw_window_gate.sv
`timescale 1ns/1ps
module tb_smw_window_gate;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h9C;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        mem_req = 1'b0;
  logic        mem_we = 1'b0;
  logic [19:0] mem_addr = '0;
  logic [7:0]  mem_wdata = 8'h00;
  logic [7:0]  cfg_rd, mem_rd, cfg_rd_l, mem_rd_l;

  int checks = 0, errors = 0;
  bit done = 1'b0, started = 1'b0;
  string cur_req = "R1";

  always #4ns clk = ~clk;

  smw_window_gate dut (
    .clk_i(clk), .rst_ni, .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rd), .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rd)
  );

  smw_window_gate #(.LEGACY(1'b1)) dut_leg (
    .clk_i(clk), .rst_ni, .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rd_l), .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rd_l)
  );

  // behavioural reference: state 0 open, 1 negotiated, 2 locked (equals read code)
  int m_st, m_rd, l_reg, l_rd;
  int m_ram[256];
  int l_ram[256];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_rd = 0; l_reg = 0; l_rd = 0;
    end else begin
      if (mem_req) begin
        automatic int idx = int'(mem_addr[7:0]);
        automatic bit inwin = (mem_addr >= 20'h30000) && (mem_addr < 20'h50000);
        if (mem_we) begin
          if (!(m_st == 2 && inwin)) m_ram[idx] = int'(mem_wdata);
          l_ram[idx] = int'(mem_wdata);
        end else begin
          m_rd = (m_st == 2 && inwin) ? 255 : m_ram[idx];
          l_rd = l_ram[idx];
        end
      end
      if (cfg_wr && cfg_addr == 8'h9C) begin
        l_reg = int'(cfg_wdata);
        if (m_st == 0 && cfg_wdata == 8'hFF) m_st = 1;
        else if (m_st == 1 && cfg_wdata == 8'h02) m_st = 2;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check({cur_req, " cfg"},     int'(cfg_rd),   (cfg_addr == 8'h9C) ? m_st  : 0);
      check({cur_req, " mem"},     int'(mem_rd),   m_rd);
      check({cur_req, " leg cfg"}, int'(cfg_rd_l), (cfg_addr == 8'h9C) ? l_reg : 0);
      check({cur_req, " leg mem"}, int'(mem_rd_l), l_rd);
    end
  end

  task automatic cfg_write(logic [7:0] a, logic [7:0] v);
    @(negedge clk); #1ns;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1ns;
    cfg_wr = 1'b0; cfg_addr = 8'h9C;
  endtask

  task automatic mem_write(logic [19:0] a, logic [7:0] v);
    @(negedge clk); #1ns;
    mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = v;
    @(posedge clk); #1ns;
    mem_req = 1'b0; mem_we = 1'b0;
  endtask

  task automatic mem_read(logic [19:0] a, int exp, int exp_l, string tag);
    @(negedge clk); #1ns;
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
    @(posedge clk); #1ns;
    mem_req = 1'b0;
    check(tag, int'(mem_rd), exp);
    if (exp_l >= 0) check({tag, " legacy"}, int'(mem_rd_l), exp_l);
  endtask

  task automatic do_reset();
    @(negedge clk); #1ns;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    #1ns rst_ni = 1'b1;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_ram[i]) begin m_ram[i] = 0; l_ram[i] = 0; end
    repeat (2) @(negedge clk);
    #1ns rst_ni = 1'b1;
    started = 1'b1;

    // R1 reset state
    #1ns;
    check("R1 reset cfg", int'(cfg_rd), 0);
    check("R1 reset rdata", int'(mem_rd), 0);
    for (int i = 0; i < 256; i++) mem_write(20'(i), 8'(i) ^ 8'h5A);
    mem_write(20'h30000, 8'h32);
    mem_read(20'h30000, 8'h32, 8'h32, "R1 window is RAM");
    mem_read(20'h30100, 8'h32, 8'h32, "R10 alias modulo 256");

    // R2 ignored values before negotiation
    cur_req = "R2";
    for (int v = 0; v < 255; v++) begin
      cfg_write(8'h9C, 8'(v));
      check("R2 ignored write", int'(cfg_rd), 0);
      check("R8 legacy readback", int'(cfg_rd_l), v);
    end

    // R9 other offsets
    cur_req = "R9";
    cfg_write(8'h9D, 8'hFF);
    check("R9 write elsewhere", int'(cfg_rd), 0);
    @(negedge clk); #1ns cfg_addr = 8'h9D; #1ns;
    check("R9 read elsewhere", int'(cfg_rd), 0);
    check("R9 read elsewhere legacy", int'(cfg_rd_l), 0);
    cfg_addr = 8'h9C; #1ns;
    check("R9 legacy unchanged", int'(cfg_rd_l), 8'hFE);

    // R3 negotiate
    cur_req = "R3";
    cfg_write(8'h9C, 8'hFF);
    check("R3 negotiated", int'(cfg_rd), 1);

    // R4 wrong codes, then lock
    cur_req = "R4";
    cfg_write(8'h9C, 8'h05); check("R4 hold 05", int'(cfg_rd), 1);
    cfg_write(8'h9C, 8'hFF); check("R4 hold FF", int'(cfg_rd), 1);
    cfg_write(8'h9C, 8'h00); check("R4 hold 00", int'(cfg_rd), 1);
    mem_read(20'h30000, 8'h32, 8'h32, "R4 window open before lock");
    cfg_write(8'h9C, 8'h02); check("R4 locked", int'(cfg_rd), 2);

    // R6 black hole and edges
    cur_req = "R6";
    mem_read(20'h30000, 8'hFF, 8'h32, "R6 base hole");
    mem_write(20'h30000, 8'h77);
    mem_read(20'h30000, 8'hFF, 8'h77, "R6 write dropped");
    mem_read(20'h4FFFF, 8'hFF, 8'hA5, "R6 top edge hole");
    mem_read(20'h2FFFF, 8'hA5, 8'hA5, "R6 below window");
    mem_read(20'h50000, 8'h32, 8'h77, "R6 above window");
    mem_write(20'h50001, 8'h44);
    mem_read(20'h50001, 8'h44, 8'h44, "R6 outside write");

    // R5 immutability
    cur_req = "R5";
    for (int v = 0; v < 256; v++) begin
      cfg_write(8'h9C, 8'(v));
      check("R5 locked immutable", int'(cfg_rd), 2);
      check("R8 legacy readback", int'(cfg_rd_l), v);
    end
    mem_read(20'h3ABCD, 8'hFF, -1, "R6 mid window");

    // R7 reset releases lock, keeps RAM
    cur_req = "R7";
    do_reset();
    #1ns;
    check("R7 cfg cleared", int'(cfg_rd), 0);
    check("R7 legacy cleared", int'(cfg_rd_l), 0);
    mem_read(20'h30000, 8'h32, 8'h77, "R7 RAM kept");
    mem_write(20'h30000, 8'h23);
    mem_read(20'h30000, 8'h23, 8'h23, "R7 window writable");
    cfg_write(8'h9C, 8'hFF);
    check("R7 negotiable again", int'(cfg_rd), 1);

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule